// File: doc/BRIEF.md
# Serial Flash Read Responder

This block sits on the slave side of a four-wire serial link and answers read requests the way a serial flash memory would. The host pulls chip-select low, clocks in an opcode, a 24-bit byte address and, for the fast variant, eight throw-away clocks. The block then returns bytes from its internal byte array, most significant bit first, for as long as chip-select stays low. The address steps forward after every byte and wraps from the top of the array back to zero.

The serial pins are sampled by the block's own system clock through two-stage synchronisers, and serial clock edges are found from the synchronised copy. The serial clock must therefore be several system clocks per half period. The array is a synchronous single-read-port byte memory with `ARRAY_AW` address bits: 20 bits gives the full 1 MiB, and the default is smaller. A separate write port lets a test environment fill the array without using the serial link. The output pin comes with an enable that models high impedance.

Top module: `flash_read_responder`

## Requirements
- R1: After reset, and whenever chip-select (`cs_n`) is high, `miso_oe` is 0. A rising edge on `cs_n` ends any transfer at any point.
- R2: Opcode 0x03 followed by a 24-bit address returns the byte stored at that address. Opcode, address and data all travel most significant bit first.
- R3: Opcode 0x0B takes a 24-bit address followed by eight dummy clocks, and the `mosi` value during those clocks is ignored. Data then follows exactly as for 0x03. `mosi` is also ignored while data is streaming out.
- R4: `miso_oe` stays 0 while opcode, address and dummy bits are clocked in. The first data bit is driven on the first falling `sclk` edge after the last address bit (0x03) or the last dummy bit (0x0B) has been sampled.
- R5: `mosi` is sampled on rising `sclk` edges and `miso` changes only on falling edges. Both idle levels of `sclk` (low for mode 0, high for mode 3) work.
- R6: While `cs_n` stays low, successive bytes come from successive addresses with no gap.
- R7: After the byte at the highest array address (2^ARRAY_AW − 1) comes the byte at address 0.
- R8: Only the low `ARRAY_AW` bits of the 24-bit address select the byte. The upper bits are ignored.
- R9: Any opcode other than 0x03 or 0x0B keeps `miso_oe` at 0 until `cs_n` goes high.
- R10: After a transfer is cut short by `cs_n` going high, whether in the address or in the data, the next transfer decodes its opcode from the first bit again.
- R11: With `bd_we` high, `bd_data` is written to array address `bd_addr` on the clock edge. Later serial reads return the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also used to sample the serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip-select, active low |
| sclk | input | 1 | Serial clock from the host |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| miso_oe | output | 1 | Output enable for `miso`; 0 models high impedance |
| bd_we | input | 1 | Backdoor array write strobe |
| bd_addr | input | ARRAY_AW | Backdoor array write address |
| bd_data | input | 8 | Backdoor array write data |

## Verification
The bench targets several corner cases:
- Wrap-around: a read starting three bytes below the top of the array. A design with an off-by-one mask would repeat or skip the top byte or stray past zero.
- Address decoding: an address with its upper bits set. A design that used them would return a different byte.
- Dummy phase: a fast read with a non-zero dummy pattern and toggling data-phase input. A wrong dummy count shifts every returned byte by one or more bits.
- Aborted transfers: `cs_n` is raised mid-address and mid-byte. A design that kept its bit counter would misalign the following opcode.
- Output enable and clock modes: the enable is checked at every sampled clock during headers and unknown opcodes. Mode 3 with its leading falling edge catches designs that start shifting too early.

// File: rtl/frr_pkg.sv
// Shared definitions for the serial flash read responder.
package frr_pkg;

    // Phases of one chip-select-low transfer.
    typedef enum logic [2:0] {
        ST_CMD,
        ST_ADDR,
        ST_DUMMY,
        ST_DATA,
        ST_IGNORE
    } rd_state_e;

    localparam logic [7:0] OP_READ      = 8'h03;
    localparam logic [7:0] OP_FAST_READ = 8'h0B;

    localparam int CMD_BITS   = 8;
    localparam int ADDR_BITS  = 24;
    localparam int DUMMY_BITS = 8;

endpackage

// File: rtl/frr_sync.sv
// Two-flop synchroniser for a bundle of asynchronous pins.
// Assumes each pin is stable for several clk periods, so the bits of
// the bundle need no mutual coherence. RST_VAL sets the reset value.
module frr_sync #(
    parameter int           W       = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] meta_q;

    // Two register stages per pin against metastability.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end

endmodule

// File: rtl/frr_array.sv
// Byte array with one synchronous read port and one write port.
// Read data appears one clk after raddr. Contents are not reset.
module frr_array #(
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);

    localparam int DEPTH = 1 << AW;

    logic [7:0] mem [DEPTH];

    // Storage update from the write port.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Registered read of the addressed byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else begin
            rdata <= mem[raddr];
        end
    end

endmodule

// File: rtl/frr_engine.sv
// Transfer engine. It decodes the opcode, collects the address, counts
// the dummy clocks and shifts bytes out.
// Assumes synchronised pins and an sclk half period of at least four clk.
// The array read data must lag rd_addr by one clk.
module frr_engine
    import frr_pkg::*;
#(
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n_s,
    input  logic          sclk_s,
    input  logic          mosi_s,
    input  logic [7:0]    rd_data,
    output logic [AW-1:0] rd_addr,
    output logic          so,
    output logic          so_oe
);

    localparam logic [4:0] CMD_LAST   = 5'(CMD_BITS - 1);
    localparam logic [4:0] ADDR_LAST  = 5'(ADDR_BITS - 1);
    localparam logic [4:0] DUMMY_LAST = 5'(DUMMY_BITS - 1);

    rd_state_e     state_q;
    logic          sclk_d;
    logic          rise, fall, cs_hi;
    logic [4:0]    cnt_q;
    logic [23:0]   shin_q;
    logic [23:0]   shin_nx;
    logic          fast_q;
    logic [6:0]    sh_q;
    logic [2:0]    bitc_q;
    logic          out_q;
    logic          oe_q;
    logic [AW-1:0] addr_q;
    logic          addr_done;
    logic          byte_load;

    assign rise      = sclk_s & ~sclk_d;
    assign fall      = ~sclk_s & sclk_d;
    assign cs_hi     = cs_n_s;
    assign shin_nx   = {shin_q[22:0], mosi_s};
    assign addr_done = rise && (state_q == ST_ADDR) && (cnt_q == ADDR_LAST);
    assign byte_load = fall && (state_q == ST_DATA) && (bitc_q == 3'd0);

    // Previous serial clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_d <= 1'b0;
        end else begin
            sclk_d <= sclk_s;
        end
    end

    // Header phases: opcode decode, address and dummy counting.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_hi) begin
            state_q <= ST_CMD;
            cnt_q   <= '0;
            shin_q  <= '0;
            fast_q  <= 1'b0;
        end else if (rise) begin
            unique case (state_q)
                ST_CMD: begin
                    shin_q <= shin_nx;
                    if (cnt_q == CMD_LAST) begin
                        cnt_q <= '0;
                        if (shin_nx[7:0] == OP_READ) begin
                            state_q <= ST_ADDR;
                            fast_q  <= 1'b0;
                        end else if (shin_nx[7:0] == OP_FAST_READ) begin
                            state_q <= ST_ADDR;
                            fast_q  <= 1'b1;
                        end else begin
                            state_q <= ST_IGNORE;
                        end
                    end else begin
                        cnt_q <= cnt_q + 5'd1;
                    end
                end
                ST_ADDR: begin
                    shin_q <= shin_nx;
                    if (cnt_q == ADDR_LAST) begin
                        cnt_q   <= '0;
                        state_q <= fast_q ? ST_DUMMY : ST_DATA;
                    end else begin
                        cnt_q <= cnt_q + 5'd1;
                    end
                end
                ST_DUMMY: begin
                    if (cnt_q == DUMMY_LAST) begin
                        cnt_q   <= '0;
                        state_q <= ST_DATA;
                    end else begin
                        cnt_q <= cnt_q + 5'd1;
                    end
                end
                default: begin
                    state_q <= state_q;
                end
            endcase
        end
    end

    // Byte address pointer: loaded from the header, stepped per byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (!cs_hi && addr_done) begin
            addr_q <= shin_nx[AW-1:0];
        end else if (!cs_hi && byte_load) begin
            addr_q <= addr_q + 1'b1;
        end
    end

    // Output shifter: a new bit on every falling sclk edge in the data phase.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_hi) begin
            sh_q   <= '0;
            bitc_q <= '0;
            out_q  <= 1'b0;
            oe_q   <= 1'b0;
        end else if (fall && (state_q == ST_DATA)) begin
            oe_q   <= 1'b1;
            bitc_q <= bitc_q + 3'd1;
            if (bitc_q == 3'd0) begin
                out_q <= rd_data[7];
                sh_q  <= rd_data[6:0];
            end else begin
                out_q <= sh_q[6];
                sh_q  <= {sh_q[5:0], 1'b0};
            end
        end
    end

    assign rd_addr = addr_q;
    assign so      = out_q;
    assign so_oe   = oe_q;

    // R1
    idle_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_hi |=> !oe_q);

    // R5
    out_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fall && !cs_hi) |=> $stable(out_q));

    // R4
    oe_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe_q) |-> ($past(fall) && $past(state_q) == ST_DATA));

    // R9
    ignore_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IGNORE) |-> !oe_q);

    // R6
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_load && !cs_hi) |=> (addr_q == AW'($past(addr_q) + 1'b1)));

endmodule

// File: rtl/flash_read_responder.sv
// Top of the serial flash read responder. It synchronises the serial
// pins, runs the transfer engine and holds the byte array.
// Assumes the host sclk half period is at least four clk periods.
module flash_read_responder #(
    parameter int ARRAY_AW = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cs_n,
    input  logic                sclk,
    input  logic                mosi,
    output logic                miso,
    output logic                miso_oe,
    input  logic                bd_we,
    input  logic [ARRAY_AW-1:0] bd_addr,
    input  logic [7:0]          bd_data
);

    logic [2:0]          pins_s;
    logic [ARRAY_AW-1:0] rd_addr;
    logic [7:0]          rd_data;

    frr_sync #(
        .W       (3),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cs_n, sclk, mosi}),
        .q     (pins_s)
    );

    frr_engine #(
        .AW (ARRAY_AW)
    ) u_engine (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n_s  (pins_s[2]),
        .sclk_s  (pins_s[1]),
        .mosi_s  (pins_s[0]),
        .rd_data (rd_data),
        .rd_addr (rd_addr),
        .so      (miso),
        .so_oe   (miso_oe)
    );

    frr_array #(
        .AW (ARRAY_AW)
    ) u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (bd_we),
        .waddr (bd_addr),
        .wdata (bd_data),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

endmodule

// File: tb/sim_flash_read_responder.sv
// Scoreboard bench. The driver pushes expected bytes; a monitor on sclk
// assembles received bytes, pops and compares.
module sim_flash_read_responder;

    localparam int AW    = 12;
    localparam int DEPTH = 1 << AW;
    localparam int HALF  = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs_n = 1'b1;
    logic          sclk = 1'b0;
    logic          mosi = 1'b0;
    logic          bd_we = 1'b0;
    logic [AW-1:0] bd_addr = '0;
    logic [7:0]    bd_data = '0;
    logic          miso;
    logic          miso_oe;

    int         errors = 0;
    int         checks = 0;
    logic [7:0] mdl [DEPTH];
    logic [7:0] expq [$];
    bit         rx_phase = 1'b0;
    string      cur_req = "R2";
    string      hz_req = "R4";
    int         nbits = 0;
    logic [7:0] rxb = '0;

    flash_read_responder #(.ARRAY_AW(AW)) u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n    (cs_n),
        .sclk    (sclk),
        .mosi    (mosi),
        .miso    (miso),
        .miso_oe (miso_oe),
        .bd_we   (bd_we),
        .bd_addr (bd_addr),
        .bd_data (bd_data)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wait_half();
        repeat (HALF) @(negedge clk);
    endtask

    task automatic clk_bit(input logic b);
        sclk = 1'b0;
        mosi = b;
        wait_half();
        sclk = 1'b1;
        wait_half();
    endtask

    task automatic bd_write(input int a, input logic [7:0] d);
        @(negedge clk);
        bd_we   = 1'b1;
        bd_addr = AW'(a);
        bd_data = d;
        @(negedge clk);
        bd_we = 1'b0;
    endtask

    // One chip-select window: header (optionally cut at hdr_limit bits), then data clocks.
    task automatic xfer(input logic [7:0] op, input logic [23:0] adr, input bit fast,
                        input int nbytes, input int extra, input bit mode3,
                        input int hdr_limit, input bit expect_data,
                        input string req, input string hzreq);
        logic [39:0] hdr;
        int nh;
        int total;
        hdr = {op, adr, 8'h96};
        nh = fast ? 40 : 32;
        if (hdr_limit < nh) nh = hdr_limit;
        cur_req = req;
        hz_req = hzreq;
        if (expect_data) begin
            for (int k = 0; k < nbytes; k++) begin
                expq.push_back(mdl[(int'(adr[AW-1:0]) + k) % DEPTH]);
            end
        end
        sclk = mode3;
        wait_half();
        cs_n = 1'b0;
        wait_half();
        for (int i = 0; i < nh; i++) clk_bit(hdr[39-i]);
        if (nh == (fast ? 40 : 32)) begin
            total = nbytes * 8 + extra;
            rx_phase = expect_data;
            for (int j = 0; j < total; j++) clk_bit(j[0]);
            rx_phase = 1'b0;
        end
        if (!mode3) sclk = 1'b0;
        wait_half();
        cs_n = 1'b1;
        wait_half();
        wait_half();
        // R1: released after chip-select high
        check(miso_oe == 1'b0, "R1", "oe after cs high", int'(miso_oe), 0);
        check(expq.size() == 0, req, "bytes left in scoreboard", expq.size(), 0);
        expq.delete();
    endtask

    // Monitor: samples miso on rising sclk, compares completed bytes.
    always @(posedge sclk or posedge cs_n) begin
        if (cs_n) begin
            nbits = 0;
        end else if (rx_phase) begin
            check(miso_oe == 1'b1, "R4", "oe during data", int'(miso_oe), 1);
            rxb = {rxb[6:0], miso};
            nbits++;
            if (nbits == 8) begin
                nbits = 0;
                if (expq.size() == 0) begin
                    check(1'b0, cur_req, "unexpected byte", int'(rxb), 0);
                end else begin
                    logic [7:0] e;
                    e = expq.pop_front();
                    check(rxb == e, cur_req, "data byte", int'(rxb), int'(e));
                end
            end
        end else begin
            check(miso_oe == 1'b0, hz_req, "hi-z in header", int'(miso_oe), 0);
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired: actual=hung expected=done");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        // R1: reset state
        check(miso_oe == 1'b0, "R1", "oe after reset", int'(miso_oe), 0);

        // R11: backdoor fill of the whole array
        for (int i = 0; i < DEPTH; i++) begin
            mdl[i] = 8'((i * 37 + 11) ^ (i >> 8));
            bd_write(i, mdl[i]);
        end

        // R2: plain read, mode 0
        xfer(8'h03, 24'h000010, 0, 8, 0, 0, 40, 1, "R2", "R4");
        // R3: fast read, dummy and data-phase mosi ignored
        xfer(8'h0B, 24'h000123, 1, 8, 0, 0, 40, 1, "R3", "R4");
        // R5: mode 3 plain and fast
        xfer(8'h03, 24'h000200, 0, 4, 0, 1, 40, 1, "R5", "R4");
        xfer(8'h0B, 24'h000301, 1, 4, 0, 1, 40, 1, "R5", "R4");
        // R6: long continuous stream
        xfer(8'h03, 24'h0007F0, 0, 20, 0, 0, 40, 1, "R6", "R4");
        // R7: wrap from the top of the array to zero
        xfer(8'h03, 24'(DEPTH - 3), 0, 6, 0, 0, 40, 1, "R7", "R4");
        xfer(8'h0B, 24'(DEPTH - 1), 1, 3, 0, 1, 40, 1, "R7", "R4");
        // R8: upper address bits ignored
        xfer(8'h03, 24'hABC020, 0, 3, 0, 0, 40, 1, "R8", "R4");
        // R9: unknown opcode keeps output released
        xfer(8'h9F, 24'h000000, 0, 0, 16, 0, 40, 0, "R9", "R9");
        xfer(8'h05, 24'hFFFFFF, 0, 0, 16, 1, 40, 0, "R9", "R9");
        // R10: abort inside the address, then a fresh read
        xfer(8'h03, 24'h000400, 0, 0, 0, 0, 20, 0, "R10", "R10");
        xfer(8'h03, 24'h000401, 0, 3, 0, 0, 40, 1, "R10", "R4");
        // R10: abort in the middle of a byte, then a fast read
        xfer(8'h03, 24'h000500, 0, 2, 3, 0, 40, 1, "R10", "R4");
        xfer(8'h0B, 24'h000600, 1, 3, 0, 0, 40, 1, "R10", "R4");
        // R11: overwrite one byte through the backdoor and read it back
        mdl[16'h055] = 8'hC3;
        bd_write(16'h055, 8'hC3);
        xfer(8'h03, 24'h000054, 0, 3, 0, 0, 40, 1, "R11", "R4");

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule